// File: doc/BRIEF.md
# Exception Entry and Return Sequencer

This block works out the architectural state changes a 32-bit RISC core needs when it takes an exception or leaves one. The core offers a one-cycle request with a vector number, the address of the faulting instruction, a flag that marks a branch delay slot, and its current status word. In the next cycle the block presents the new status word with a write strobe. It also presents a fetch redirect to the handler and a pulse that cancels any pending delay slot. It keeps three saved registers: the return PC, the saved status and the fault address.

A return request restores the status word from the saved copy and forces the always-one bit. It then redirects fetch to the saved return PC. A breakpoint trap does not vector: it raises a halt pulse for the debugger along with the trap address. A vector number the block does not know raises an error pulse and changes nothing.

All results are registered. They appear after the clock edge that samples the request, and the pulses last exactly one cycle.

Top module: `exc_unit`

## Requirements
- R1: Known vector numbers are 1 reset, 2 bus error, 6 alignment, 7 illegal instruction, 11 range, 12 system call, 13 floating point and 14 trap. Each vectoring class (all except 14) is entered when `req_i` is high at a clock edge, and `redir_o`, `sr_we_o` and `dslot_clr_o` pulse high for the following cycle only.
- R2: For vectors 12 and 13 the saved return PC becomes `pc_i + 4`, or `pc_i` when `dslot_i` is high.
- R3: For vectors 2, 6, 7 and 11 the saved return PC becomes `pc_i`, or `pc_i - 4` when `dslot_i` is high.
- R4: Vector 1 leaves the saved return PC unchanged but otherwise enters like any vectoring class.
- R5: On every vectoring entry the saved status becomes `sr_i`, and `sr_o` becomes `sr_i` with bit 13 (delay-slot exception) replaced by `dslot_i`.
- R6: On entry `redir_pc_o` = (`sr_i` bit 14 ? 0xF000_0000 : 0) + (vector << 8).
- R7: Vector 14 pulses `halt_o` for one cycle with `halt_pc_o` = `pc_i`. It raises no redirect and no status write, and leaves every saved register unchanged.
- R8: Vector 7 loads the fault-address register with `pc_i`; no other request changes it.
- R9: Any other vector number pulses `err_o` for one cycle. It raises no redirect, no halt and no status write, and leaves the saved registers unchanged.
- R10: A return (`rfe_i` high, `req_i` low) drives `sr_o` to the saved status with bit 15 forced to 1. It pulses `sr_we_o`, `redir_o` and `dslot_clr_o`, with `redir_pc_o` equal to the saved return PC.
- R11: When `req_i` and `rfe_i` are high in the same cycle, the exception request wins and the return is dropped.
- R12: After reset every output and every saved register is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Exception request, one cycle |
| vec_i | input | 4 | Exception vector number |
| pc_i | input | 32 | Address of the faulting instruction |
| dslot_i | input | 1 | Faulting instruction sits in a delay slot |
| sr_i | input | 32 | Current status word |
| rfe_i | input | 1 | Return-from-exception request, one cycle |
| redir_o | output | 1 | Fetch redirect pulse |
| redir_pc_o | output | 32 | Redirect target |
| sr_we_o | output | 1 | Status word write strobe |
| sr_o | output | 32 | New status word |
| dslot_clr_o | output | 1 | Cancel pending delay slot |
| halt_o | output | 1 | Debug halt pulse for a trap |
| halt_pc_o | output | 32 | Address of the trap |
| err_o | output | 1 | Unknown vector pulse |
| epcr_o | output | 32 | Saved return PC |
| esr_o | output | 32 | Saved status word |
| eear_o | output | 32 | Saved fault address |

## Verification
Several properties are checked on every cycle. At most one of redirect, halt and error fires in a cycle. Error and halt cycles leave the saved registers stable. The delay-slot bit and the saved status follow the request. A return sets the always-one bit and redirects. Handler targets keep their low eight bits clear. The exact return-PC arithmetic for each class with and without a delay slot is shown only by the bench scenarios. So are the reset vector keeping the old return PC, the fault-address capture on illegal instructions, the exception-over-return priority, and a return right after an entry picking up the fresh return PC.

// File: rtl/exc_pkg.sv
package exc_pkg;
  typedef enum logic [2:0] {
    EC_NONE,   // unknown vector
    EC_RESET,
    EC_CUR,    // resume at the faulting instruction
    EC_NEXT,   // resume after the faulting instruction
    EC_TRAP
  } exc_class_e;

  localparam int unsigned VEC_RESET   = 1;
  localparam int unsigned VEC_BUSERR  = 2;
  localparam int unsigned VEC_ALIGN   = 6;
  localparam int unsigned VEC_ILLEGAL = 7;
  localparam int unsigned VEC_RANGE   = 11;
  localparam int unsigned VEC_SYSCALL = 12;
  localparam int unsigned VEC_FPE     = 13;
  localparam int unsigned VEC_TRAP    = 14;

  localparam int unsigned SR_DSX = 13;
  localparam int unsigned SR_EPH = 14;
  localparam int unsigned SR_FO  = 15;
endpackage

// File: rtl/exc_classify.sv
module exc_classify
  import exc_pkg::*;
#(
  parameter int unsigned VEC_W = 4
) (
  input  logic [VEC_W-1:0] vec_i,
  output exc_class_e       cls_o,
  output logic             illegal_o
);
  always_comb begin
    cls_o     = EC_NONE;
    illegal_o = 1'b0;
    case (int'(vec_i))
      VEC_RESET:                              cls_o = EC_RESET;
      VEC_BUSERR, VEC_ALIGN, VEC_RANGE:       cls_o = EC_CUR;
      VEC_ILLEGAL: begin
        cls_o     = EC_CUR;
        illegal_o = 1'b1;
      end
      VEC_SYSCALL, VEC_FPE:                   cls_o = EC_NEXT;
      VEC_TRAP:                               cls_o = EC_TRAP;
      default:                                cls_o = EC_NONE;
    endcase
  end
endmodule

// File: rtl/exc_epc_calc.sv
module exc_epc_calc
  import exc_pkg::*;
#(
  parameter int unsigned XLEN       = 32,
  parameter int unsigned INSN_BYTES = 4
) (
  input  exc_class_e      cls_i,
  input  logic [XLEN-1:0] pc_i,
  input  logic            dslot_i,
  input  logic [XLEN-1:0] epc_cur_i,
  output logic [XLEN-1:0] epc_o
);
  localparam logic [XLEN-1:0] STEP = XLEN'(INSN_BYTES);

  always_comb begin
    case (cls_i)
      EC_NEXT: epc_o = dslot_i ? pc_i : pc_i + STEP;
      EC_CUR:  epc_o = dslot_i ? pc_i - STEP : pc_i;
      default: epc_o = epc_cur_i;
    endcase
  end
endmodule

// File: rtl/exc_vector.sv
module exc_vector #(
  parameter int unsigned    XLEN      = 32,
  parameter int unsigned    VEC_W     = 4,
  parameter int unsigned    VEC_SHIFT = 8,
  parameter logic [XLEN-1:0] HI_BASE  = 32'hF000_0000
) (
  input  logic             hi_i,
  input  logic [VEC_W-1:0] vec_i,
  output logic [XLEN-1:0]  pc_o
);
  localparam int unsigned OFS_W = VEC_W + VEC_SHIFT;

  logic [XLEN-1:0] ofs;

  generate
    if (OFS_W >= XLEN) begin : g_trunc
      assign ofs = XLEN'({vec_i, {VEC_SHIFT{1'b0}}});
    end else begin : g_pad
      assign ofs = {{(XLEN-OFS_W){1'b0}}, vec_i, {VEC_SHIFT{1'b0}}};
    end
  endgenerate

  assign pc_o = (hi_i ? HI_BASE : '0) + ofs;
endmodule

// File: rtl/exc_unit.sv
module exc_unit
  import exc_pkg::*;
#(
  parameter int unsigned     XLEN       = 32,
  parameter int unsigned     VEC_W      = 4,
  parameter int unsigned     INSN_BYTES = 4,
  parameter int unsigned     VEC_SHIFT  = 8,
  parameter logic [XLEN-1:0] HI_BASE    = 32'hF000_0000
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic [VEC_W-1:0] vec_i,
  input  logic [XLEN-1:0]  pc_i,
  input  logic             dslot_i,
  input  logic [XLEN-1:0]  sr_i,
  input  logic             rfe_i,
  output logic             redir_o,
  output logic [XLEN-1:0]  redir_pc_o,
  output logic             sr_we_o,
  output logic [XLEN-1:0]  sr_o,
  output logic             dslot_clr_o,
  output logic             halt_o,
  output logic [XLEN-1:0]  halt_pc_o,
  output logic             err_o,
  output logic [XLEN-1:0]  epcr_o,
  output logic [XLEN-1:0]  esr_o,
  output logic [XLEN-1:0]  eear_o
);
  exc_class_e      cls;
  logic            is_illegal;
  logic [XLEN-1:0] epc_next, handler_pc, sr_entry;
  logic            do_vec;

  logic [XLEN-1:0] epcr_q, esr_q, eear_q, redir_pc_q, sr_q, halt_pc_q;
  logic            redir_q, sr_we_q, dclr_q, halt_q, err_q;

  exc_classify #(.VEC_W(VEC_W)) u_cls (
    .vec_i     (vec_i),
    .cls_o     (cls),
    .illegal_o (is_illegal)
  );

  exc_epc_calc #(.XLEN(XLEN), .INSN_BYTES(INSN_BYTES)) u_epc (
    .cls_i     (cls),
    .pc_i      (pc_i),
    .dslot_i   (dslot_i),
    .epc_cur_i (epcr_q),
    .epc_o     (epc_next)
  );

  exc_vector #(.XLEN(XLEN), .VEC_W(VEC_W), .VEC_SHIFT(VEC_SHIFT), .HI_BASE(HI_BASE)) u_vec (
    .hi_i  (sr_i[SR_EPH]),
    .vec_i (vec_i),
    .pc_o  (handler_pc)
  );

  assign do_vec = req_i && (cls != EC_NONE) && (cls != EC_TRAP);

  always_comb begin
    sr_entry         = sr_i;
    sr_entry[SR_DSX] = dslot_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      epcr_q     <= '0;
      esr_q      <= '0;
      eear_q     <= '0;
      redir_pc_q <= '0;
      sr_q       <= '0;
      halt_pc_q  <= '0;
      redir_q    <= 1'b0;
      sr_we_q    <= 1'b0;
      dclr_q     <= 1'b0;
      halt_q     <= 1'b0;
      err_q      <= 1'b0;
    end else begin
      redir_q <= 1'b0;
      sr_we_q <= 1'b0;
      dclr_q  <= 1'b0;
      halt_q  <= 1'b0;
      err_q   <= 1'b0;
      if (req_i) begin
        case (cls)
          EC_TRAP: begin
            halt_q    <= 1'b1;
            halt_pc_q <= pc_i;
          end
          EC_NONE: err_q <= 1'b1;
          default: begin
            epcr_q     <= epc_next;
            esr_q      <= sr_i;
            if (is_illegal) eear_q <= pc_i;
            sr_q       <= sr_entry;
            sr_we_q    <= 1'b1;
            redir_q    <= 1'b1;
            redir_pc_q <= handler_pc;
            dclr_q     <= 1'b1;
          end
        endcase
      end else if (rfe_i) begin
        sr_q         <= esr_q;
        sr_q[SR_FO]  <= 1'b1;
        sr_we_q      <= 1'b1;
        redir_q      <= 1'b1;
        redir_pc_q   <= epcr_q;
        dclr_q       <= 1'b1;
      end
    end
  end

  assign redir_o     = redir_q;
  assign redir_pc_o  = redir_pc_q;
  assign sr_we_o     = sr_we_q;
  assign sr_o        = sr_q;
  assign dslot_clr_o = dclr_q;
  assign halt_o      = halt_q;
  assign halt_pc_o   = halt_pc_q;
  assign err_o       = err_q;
  assign epcr_o      = epcr_q;
  assign esr_o       = esr_q;
  assign eear_o      = eear_q;

  p_one_outcome_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({redir_o, halt_o, err_o}));

  p_err_no_save_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> ($stable(epcr_o) && $stable(esr_o) && $stable(eear_o) && !sr_we_o));

  p_trap_no_save_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_o |-> ($stable(epcr_o) && $stable(esr_o) && !sr_we_o && !redir_o));

  p_entry_status_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    do_vec |=> (sr_we_o && sr_o[SR_DSX] == $past(dslot_i) && esr_o == $past(sr_i)));

  p_handler_align_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    do_vec |=> (redir_o && redir_pc_o[VEC_SHIFT-1:0] == '0));

  p_return_fo_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rfe_i && !req_i) |=> (sr_we_o && sr_o[SR_FO] && redir_o && redir_pc_o == epcr_o));

  p_dclr_pulse_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dslot_clr_o |-> (redir_o && sr_we_o));
endmodule

// File: tb/sim_exc_unit.sv
module sim_exc_unit;
  typedef struct packed {
    logic        redir;
    logic [31:0] redir_pc;
    logic        sr_we;
    logic [31:0] sr;
    logic        dclr;
    logic        halt;
    logic [31:0] halt_pc;
    logic        err;
    logic [31:0] epcr;
    logic [31:0] esr;
    logic [31:0] eear;
  } obs_t;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 1'b0, dslot_i = 1'b0, rfe_i = 1'b0;
  logic [3:0]  vec_i = '0;
  logic [31:0] pc_i = '0, sr_i = '0;
  logic        redir_o, sr_we_o, dslot_clr_o, halt_o, err_o;
  logic [31:0] redir_pc_o, sr_o, halt_pc_o, epcr_o, esr_o, eear_o;

  int n_chk = 0, n_fail = 0;
  obs_t  exp_q[$];
  string tag_q[$];
  obs_t  m;  // bench model of held state
  bit    done = 0;

  always #10 clk = ~clk;

  exc_unit u0 (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req_i), .vec_i(vec_i), .pc_i(pc_i),
    .dslot_i(dslot_i), .sr_i(sr_i), .rfe_i(rfe_i), .redir_o(redir_o),
    .redir_pc_o(redir_pc_o), .sr_we_o(sr_we_o), .sr_o(sr_o),
    .dslot_clr_o(dslot_clr_o), .halt_o(halt_o), .halt_pc_o(halt_pc_o),
    .err_o(err_o), .epcr_o(epcr_o), .esr_o(esr_o), .eear_o(eear_o)
  );

  function automatic obs_t observe();
    obs_t o;
    o = '{redir_o, redir_pc_o, sr_we_o, sr_o, dslot_clr_o, halt_o, halt_pc_o,
          err_o, epcr_o, esr_o, eear_o};
    return o;
  endfunction

  task automatic check(string tag, obs_t got, obs_t exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // Driver: applies one cycle of stimulus and queues the expected result.
  task automatic send(bit rq, bit rf, int vec, logic [31:0] pc, bit ds,
                      logic [31:0] sr, string tag);
    obs_t e;
    @(negedge clk);
    req_i = rq; rfe_i = rf; vec_i = 4'(vec); pc_i = pc; dslot_i = ds; sr_i = sr;
    m.redir = 0; m.sr_we = 0; m.dclr = 0; m.halt = 0; m.err = 0;
    if (rq) begin
      if (vec == 14) begin
        m.halt = 1; m.halt_pc = pc;
      end else if (vec inside {1, 2, 6, 7, 11, 12, 13}) begin
        if (vec inside {12, 13}) m.epcr = ds ? pc : pc + 32'd4;
        else if (vec != 1)       m.epcr = ds ? pc - 32'd4 : pc;
        if (vec == 7) m.eear = pc;
        m.esr = sr;
        m.sr = {sr[31:14], ds, sr[12:0]};
        m.sr_we = 1; m.redir = 1; m.dclr = 1;
        m.redir_pc = (sr[14] ? 32'hF000_0000 : 32'h0) + (32'(vec) << 8);
      end else begin
        m.err = 1;
      end
    end else if (rf) begin
      m.sr = m.esr | 32'h0000_8000;
      m.sr_we = 1; m.redir = 1; m.dclr = 1;
      m.redir_pc = m.epcr;
    end
    e = m;
    exp_q.push_back(e);
    tag_q.push_back(tag);
  endtask

  task automatic idle(string tag);
    send(0, 0, 0, 32'h0, 0, 32'h0, tag);
  endtask

  // Monitor: compares each cycle's result with the queued expectation.
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (exp_q.size() > 0) check(tag_q.pop_front(), observe(), exp_q.pop_front());
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    m = '0;
    repeat (3) @(negedge clk);
    check("R12 reset state", observe(), '0);
    rst_ni = 1'b1;
    idle("R12 idle after reset");

    send(1, 0, 12, 32'h0000_1000, 0, 32'h0000_8001, "R2 syscall");
    idle("R1 pulse ends");
    send(1, 0, 13, 32'h0000_2000, 1, 32'h0000_C001, "R2 R6 fpe dslot hi base");
    send(1, 0, 2,  32'h0000_3000, 0, 32'h0000_0001, "R3 bus error");
    send(1, 0, 6,  32'h0000_3010, 1, 32'h0000_2001, "R3 R5 align dslot");
    send(1, 0, 11, 32'h0000_3020, 0, 32'h0000_2003, "R3 R5 range clears dsx");
    send(1, 0, 7,  32'h0000_4444, 1, 32'h0000_4000, "R8 illegal");
    send(1, 0, 1,  32'h0000_9999, 0, 32'h0000_0005, "R4 reset keeps epc");
    send(1, 0, 14, 32'h0000_5550, 1, 32'h1234_5678, "R7 trap halts");
    idle("R7 halt ends");
    send(1, 0, 5,  32'h0000_6000, 0, 32'h0000_0000, "R9 unknown 5");
    send(1, 0, 0,  32'h0000_6004, 0, 32'h0000_0000, "R9 unknown 0");
    send(1, 0, 15, 32'h0000_6008, 1, 32'h0000_4000, "R9 unknown 15");
    idle("R9 idle");
    send(0, 1, 0,  32'h0, 0, 32'h0, "R10 return");
    idle("R10 pulse ends");
    send(1, 1, 12, 32'h0000_7000, 0, 32'h0000_0200, "R11 request beats return");
    send(0, 1, 0,  32'h0, 0, 32'h0, "R10 return after entry");
    send(1, 0, 7,  32'h0000_8000, 0, 32'h0000_4001, "R8 R6 illegal hi base");
    send(1, 0, 6,  32'h0000_8100, 0, 32'h0000_0001, "R8 align keeps eear");
    send(1, 1, 14, 32'h0000_8200, 0, 32'h0000_0000, "R11 trap beats return");
    send(0, 1, 0,  32'h0, 0, 32'h0, "R10 return restores");
    idle("R1 final idle");
    idle("R1 final idle 2");

    @(negedge clk);
    @(negedge clk);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule